// File: doc/BRIEF.md
# Link-Escape Byte Codec

This block applies and removes the byte escaping used on a ZMODEM-style serial link. The encoder side takes a byte stream and replaces every byte that must not travel raw with a two-byte pair. The pair is the escape byte 0x18 followed by the original byte with bit 6 flipped. The decoder side takes a raw link stream, strips the escape prefixes and hands the restored bytes downstream. Both directions move one byte per valid/ready handshake.

While the decoder unescapes, it also watches the raw stream for two things. One is the binary-header opener: a pad character (0x2A), then the escape byte, then the binary marker (0x41). The other is a run of consecutive escape bytes, which the far end sends to abort the session. A malformed escape sets a sticky error flag, and an abort run sets a sticky abort flag. Both flags clear only on reset.

Top module: `zlink_codec`

## Requirements
- R1: An encoder input byte outside the escape set appears unchanged on `enc_data_o` in the same cycle. It is consumed when `enc_ready_i` is high.
- R2: The escape set is 0x18, 0x11, 0x91, 0x13 and 0x93. For a byte in this set, the encoder emits 0x18 first and then the byte XOR 0x40.
- R3: While the encoder emits the second byte of a pair, `enc_ready_o` is low. The output therefore carries at most two bytes per input byte, and the bytes keep their order.
- R4: When the decoder is not already inside an escape, it takes an input 0x18 as a prefix and produces no output for it. After a prefix, a byte with bit 6 = 1 and bit 5 = 0 is output XOR 0x40, for either value of bit 7.
- R5: After a prefix, the byte 0x6C decodes to 0x7F and the byte 0x6D decodes to 0xFF. Neither sets the error flag.
- R6: After a prefix, a byte that matches no rule is output unchanged. `esc_err_o` then rises in the next cycle and stays high until reset.
- R7: A decoder input byte that is not 0x18 and does not follow a prefix is output unchanged. `dec_ready_o` then follows `dec_ready_i`.
- R8: `hdr_seen_o` pulses for one cycle, in the cycle after the decoder accepts 0x41, if the two bytes accepted just before it were 0x2A and then 0x18.
- R9: `abort_o` rises in the cycle after the fifth consecutive accepted 0x18 and stays high until reset. Any other accepted byte resets the run count.
- R10: After reset, `abort_o`, `esc_err_o` and `hdr_seen_o` are low. Neither output stream is valid while its input stream is idle.
- R11: While the encoder holds the second byte of a pair and `enc_ready_i` is low, `enc_valid_o` stays high and `enc_data_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Raw byte offered to the encoder |
| enc_ready_o | output | 1 | Encoder accepts the raw byte |
| enc_data_i | input | 8 | Raw byte to be escaped |
| enc_valid_o | output | 1 | Link byte available from the encoder |
| enc_ready_i | input | 1 | Link side takes the encoder byte |
| enc_data_o | output | 8 | Escaped link byte |
| dec_valid_i | input | 1 | Link byte offered to the decoder |
| dec_ready_o | output | 1 | Decoder accepts the link byte |
| dec_data_i | input | 8 | Link byte to be unescaped |
| dec_valid_o | output | 1 | Restored byte available |
| dec_ready_i | input | 1 | Consumer takes the restored byte |
| dec_data_o | output | 8 | Restored byte |
| hdr_seen_o | output | 1 | One-cycle pulse: binary header opener seen |
| abort_o | output | 1 | Sticky: abort run of escape bytes seen |
| esc_err_o | output | 1 | Sticky: malformed escape seen |

## Verification
Several properties are checked on every cycle by assertions:
- an escape pair's second byte follows its prefix with `enc_ready_o` low;
- that second byte holds steady under backpressure;
- the error and abort flags never fall;
- the abort run counter stays bounded and raises the flag on the fifth escape byte;
- the header pulse lasts exactly one cycle.

The byte-exact mapping through both directions can only be shown by the bench scenarios, which compare the outputs against reference functions. The same applies to keeping byte order under random backpressure, to the encoded stream decoding back to the original, and to header detection only on the exact three-byte order.

// File: rtl/zlink_pkg.sv
package zlink_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t FLIP_MASK = 8'h40;
  localparam byte_t DEL_CODE  = 8'h6C;  // escaped form of 0x7F
  localparam byte_t FF_CODE   = 8'h6D;  // escaped form of 0xFF

  function automatic logic must_escape(byte_t b, byte_t esc);
    return (b == esc) || (b == 8'h11) || (b == 8'h91) ||
           (b == 8'h13) || (b == 8'h93);
  endfunction
endpackage

// File: rtl/zlink_enc.sv
module zlink_enc
  import zlink_pkg::*;
#(
  parameter byte_t ESC_CHAR = 8'h18
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  output logic  in_ready_o,
  input  byte_t in_data_i,
  output logic  out_valid_o,
  input  logic  out_ready_i,
  output byte_t out_data_o
);
  typedef enum logic {ENC_PASS, ENC_TAIL} enc_st_e;

  enc_st_e st_q;
  byte_t   tail_q;
  logic    special;

  assign special = must_escape(in_data_i, ESC_CHAR);

  always_comb begin
    if (st_q == ENC_TAIL) begin
      out_valid_o = 1'b1;
      out_data_o  = tail_q;
      in_ready_o  = 1'b0;
    end else begin
      out_valid_o = in_valid_i;
      out_data_o  = special ? ESC_CHAR : in_data_i;
      in_ready_o  = out_ready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ENC_PASS;
      tail_q <= '0;
    end else if (st_q == ENC_PASS) begin
      if (in_valid_i && out_ready_i && special) begin
        st_q   <= ENC_TAIL;
        tail_q <= in_data_i ^ FLIP_MASK;
      end
    end else if (out_ready_i) begin
      st_q <= ENC_PASS;
    end
  end

  // R2, R3: the flipped byte follows the prefix and input is blocked meanwhile
  a_r2_tail_follows_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENC_PASS && in_valid_i && out_ready_i && special) |=>
      (out_valid_o && !in_ready_o && out_data_o == ($past(in_data_i) ^ FLIP_MASK)));

  a_r3_no_back_to_back_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && special) |=> !in_ready_o);

  a_r11_tail_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENC_TAIL && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/zlink_dec.sv
module zlink_dec
  import zlink_pkg::*;
#(
  parameter byte_t ESC_CHAR = 8'h18
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  output logic  in_ready_o,
  input  byte_t in_data_i,
  output logic  out_valid_o,
  input  logic  out_ready_i,
  output byte_t out_data_o,
  output logic  err_o
);
  logic  after_q, err_q;
  logic  take_prefix, bad, accept;
  byte_t mapped;

  always_comb begin
    bad    = 1'b0;
    mapped = in_data_i;
    if (after_q) begin
      if (in_data_i[6] && !in_data_i[5]) mapped = in_data_i ^ FLIP_MASK;
      else if (in_data_i == DEL_CODE)    mapped = 8'h7F;
      else if (in_data_i == FF_CODE)     mapped = 8'hFF;
      else                               bad    = 1'b1;
    end
  end

  assign take_prefix = !after_q && (in_data_i == ESC_CHAR);
  assign out_valid_o = in_valid_i && !take_prefix;
  assign out_data_o  = mapped;
  assign in_ready_o  = take_prefix || out_ready_i;
  assign accept      = in_valid_i && in_ready_o;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      after_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      after_q <= take_prefix;
      if (after_q && bad) err_q <= 1'b1;
    end
  end

  // R4: a swallowed prefix always makes the next byte an escaped one
  a_r4_prefix_arms_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !out_valid_o) |=> after_q);

  a_r4_escape_yields_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (after_q && in_valid_i) |-> out_valid_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: rtl/zlink_seq_mon.sv
module zlink_seq_mon
  import zlink_pkg::*;
#(
  parameter byte_t       ESC_CHAR  = 8'h18,
  parameter byte_t       PAD_CHAR  = 8'h2A,
  parameter byte_t       BIN_CHAR  = 8'h41,
  parameter int unsigned ABORT_RUN = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  byte_valid_i,
  input  byte_t byte_i,
  output logic  hdr_o,
  output logic  abort_o
);
  localparam int unsigned RUN_W = $clog2(ABORT_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(ABORT_RUN);

  typedef enum logic [1:0] {HS_IDLE, HS_PAD, HS_ESC} hdr_st_e;

  hdr_st_e          stage_q;
  logic [RUN_W-1:0] run_q;
  logic             hdr_q, abort_q;

  assign hdr_o   = hdr_q;
  assign abort_o = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= HS_IDLE;
      run_q   <= '0;
      hdr_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      hdr_q <= byte_valid_i && stage_q == HS_ESC && byte_i == BIN_CHAR;
      if (byte_valid_i) begin
        if (byte_i == PAD_CHAR)                         stage_q <= HS_PAD;
        else if (stage_q == HS_PAD && byte_i == ESC_CHAR) stage_q <= HS_ESC;
        else                                            stage_q <= HS_IDLE;

        if (byte_i != ESC_CHAR)  run_q <= '0;
        else if (run_q != RUN_LIM) run_q <= run_q + 1'b1;

        if (byte_i == ESC_CHAR && run_q == RUN_LIM - 1'b1) abort_q <= 1'b1;
      end
    end
  end

  a_r8_hdr_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_o |=> !hdr_o);

  a_r9_abort_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> abort_o);

  a_r9_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LIM);

  a_r9_abort_on_last_escape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_i == ESC_CHAR && run_q == RUN_LIM - 1'b1) |=> abort_o);
endmodule

// File: rtl/zlink_codec.sv
module zlink_codec
  import zlink_pkg::*;
#(
  parameter byte_t       ESC_CHAR  = 8'h18,
  parameter byte_t       PAD_CHAR  = 8'h2A,
  parameter byte_t       BIN_CHAR  = 8'h41,
  parameter int unsigned ABORT_RUN = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enc_valid_i,
  output logic       enc_ready_o,
  input  logic [7:0] enc_data_i,
  output logic       enc_valid_o,
  input  logic       enc_ready_i,
  output logic [7:0] enc_data_o,
  input  logic       dec_valid_i,
  output logic       dec_ready_o,
  input  logic [7:0] dec_data_i,
  output logic       dec_valid_o,
  input  logic       dec_ready_i,
  output logic [7:0] dec_data_o,
  output logic       hdr_seen_o,
  output logic       abort_o,
  output logic       esc_err_o
);
  zlink_enc #(.ESC_CHAR(ESC_CHAR)) u_enc (
    .clk_i, .rst_ni,
    .in_valid_i (enc_valid_i), .in_ready_o (enc_ready_o), .in_data_i (enc_data_i),
    .out_valid_o(enc_valid_o), .out_ready_i(enc_ready_i), .out_data_o(enc_data_o)
  );

  zlink_dec #(.ESC_CHAR(ESC_CHAR)) u_dec (
    .clk_i, .rst_ni,
    .in_valid_i (dec_valid_i), .in_ready_o (dec_ready_o), .in_data_i (dec_data_i),
    .out_valid_o(dec_valid_o), .out_ready_i(dec_ready_i), .out_data_o(dec_data_o),
    .err_o      (esc_err_o)
  );

  zlink_seq_mon #(
    .ESC_CHAR(ESC_CHAR), .PAD_CHAR(PAD_CHAR), .BIN_CHAR(BIN_CHAR), .ABORT_RUN(ABORT_RUN)
  ) u_mon (
    .clk_i, .rst_ni,
    .byte_valid_i(dec_valid_i && dec_ready_o),
    .byte_i      (dec_data_i),
    .hdr_o       (hdr_seen_o),
    .abort_o     (abort_o)
  );
endmodule

// File: tb/zlink_codec_tb.sv
module zlink_codec_tb;
  import zlink_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni;
  logic enc_valid_i, enc_ready_o, enc_valid_o, enc_ready_i;
  logic [7:0] enc_data_i, enc_data_o;
  logic dec_valid_i, dec_ready_o, dec_valid_o, dec_ready_i;
  logic [7:0] dec_data_i, dec_data_o;
  logic hdr_seen_o, abort_o, esc_err_o;

  zlink_codec u_dut (.clk_i(clk), .*);

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_special(byte_t b);
    return b == 8'h18 || b == 8'h11 || b == 8'h91 || b == 8'h13 || b == 8'h93;
  endfunction

  function automatic byte_t ref_unesc(byte_t b, output bit bad);
    bad = 1'b0;
    if (b[6] && !b[5]) return b ^ 8'h40;
    if (b == 8'h6C) return 8'h7F;
    if (b == 8'h6D) return 8'hFF;
    bad = 1'b1;
    return b;
  endfunction

  // decoder reference state
  bit m_after, m_err, m_abort, m_hdr;
  int m_run, m_stage;

  task automatic do_reset();
    rst_ni = 1'b0;
    enc_valid_i = 0; enc_ready_i = 0; enc_data_i = 0;
    dec_valid_i = 0; dec_ready_i = 0; dec_data_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_after = 0; m_err = 0; m_abort = 0; m_hdr = 0; m_run = 0; m_stage = 0;
  endtask

  task automatic dec_cycle(byte_t b, bit vld, output bit acc);
    bit bad;
    byte_t e;
    @(negedge clk);
    dec_valid_i = vld; dec_data_i = b; dec_ready_i = ($urandom % 4) != 0;
    #1;
    chk(hdr_seen_o == m_hdr, "R8", "hdr_seen_o", hdr_seen_o, m_hdr);
    chk(esc_err_o == m_err, "R6", "esc_err_o", esc_err_o, m_err);
    chk(abort_o == m_abort, "R9", "abort_o", abort_o, m_abort);
    m_hdr = 0;
    acc = 0;
    bad = 0;
    if (vld) begin
      if (!m_after && b == 8'h18) begin
        chk(dec_ready_o && !dec_valid_o, "R4", "prefix swallowed", {dec_ready_o, dec_valid_o}, 2);
      end else begin
        e = m_after ? ref_unesc(b, bad) : b;
        chk(dec_valid_o == 1'b1, "R7", "dec_valid_o", dec_valid_o, 1);
        chk(dec_ready_o == dec_ready_i, "R7", "dec_ready_o", dec_ready_o, dec_ready_i);
        if (!m_after)         chk(dec_data_o == e, "R7", "plain byte", dec_data_o, e);
        else if (bad)         chk(dec_data_o == e, "R6", "bad escape", dec_data_o, e);
        else if (b == 8'h6C || b == 8'h6D)
                              chk(dec_data_o == e, "R5", "high escape", dec_data_o, e);
        else                  chk(dec_data_o == e, "R4", "escaped byte", dec_data_o, e);
      end
      acc = dec_valid_i && dec_ready_o;
      if (acc) begin
        if (m_stage == 2 && b == 8'h41) m_hdr = 1;
        m_stage = (b == 8'h2A) ? 1 : (m_stage == 1 && b == 8'h18) ? 2 : 0;
        m_run = (b == 8'h18) ? ((m_run < 5) ? m_run + 1 : 5) : 0;
        if (m_run == 5) m_abort = 1;
        if (m_after && bad) m_err = 1;
        m_after = !m_after && b == 8'h18;
      end
    end
  endtask

  task automatic dec_send(byte_t b);
    bit acc;
    do dec_cycle(b, 1'b1, acc); while (!acc);
  endtask

  task automatic dec_idle();
    bit acc;
    dec_cycle(8'h00, 1'b0, acc);
    dec_valid_i = 0;
  endtask

  byte_t enc_in [0:255];
  byte_t enc_exp[0:511];
  bit    enc_pre[0:511];

  task automatic enc_stream(int n);
    int eo = 0, idx = 0, oidx = 0, guard = 0;
    bit pend = 0, held_v = 0;
    byte_t held_d = 0;
    for (int i = 0; i < n; i++) begin
      if (ref_special(enc_in[i])) begin
        enc_exp[eo] = 8'h18; enc_pre[eo] = 1; eo++;
        enc_exp[eo] = enc_in[i] ^ 8'h40; enc_pre[eo] = 0; eo++;
      end else begin
        enc_exp[eo] = enc_in[i]; enc_pre[eo] = 0; eo++;
      end
    end
    while (oidx < eo && guard < 5000) begin
      guard++;
      @(negedge clk);
      enc_valid_i = idx < n;
      enc_data_i  = (idx < n) ? enc_in[idx] : 8'h00;
      enc_ready_i = ($urandom % 4) != 0;
      #1;
      if (held_v) chk(enc_valid_o && enc_data_o == held_d, "R11", "tail hold", enc_data_o, held_d);
      if (pend) chk(!enc_ready_o, "R3", "ready during tail", enc_ready_o, 0);
      held_v = pend && enc_valid_o && !enc_ready_i;
      held_d = enc_data_o;
      if (enc_valid_o && enc_ready_i) begin
        chk(enc_data_o == enc_exp[oidx],
            (enc_pre[oidx] || (oidx > 0 && enc_pre[oidx-1])) ? "R2" : "R1",
            "enc byte", enc_data_o, enc_exp[oidx]);
        pend = enc_pre[oidx];
        oidx++;
      end
      if (enc_valid_i && enc_ready_o) idx++;
    end
    @(negedge clk);
    enc_valid_i = 0; enc_ready_i = 1;
    chk(oidx == eo && idx == n, "R3", "stream complete", oidx, eo);
    chk(eo <= 2 * n, "R3", "expansion bound", eo, 2 * n);
  endtask

  function automatic byte_t pick_byte();
    byte_t sp[5] = '{8'h18, 8'h11, 8'h91, 8'h13, 8'h93};
    if ($urandom % 3 == 0) return sp[$urandom % 5];
    return byte_t'($urandom % 256);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd4242);
    do_reset();
    @(negedge clk); #1;
    // R10 reset state
    chk(!enc_valid_o && !dec_valid_o, "R10", "idle valids", {enc_valid_o, dec_valid_o}, 0);
    chk(!abort_o && !esc_err_o && !hdr_seen_o, "R10", "flags", {abort_o, esc_err_o, hdr_seen_o}, 0);

    // directed encoder corners, then random
    enc_in[0] = 8'h18; enc_in[1] = 8'h11; enc_in[2] = 8'h91; enc_in[3] = 8'h13;
    enc_in[4] = 8'h93; enc_in[5] = 8'h12; enc_in[6] = 8'h98; enc_in[7] = 8'h58;
    enc_stream(8);
    for (int i = 0; i < 200; i++) enc_in[i] = pick_byte();
    enc_stream(200);

    // round trip of well-formed escaping, including 0x7F/0xFF forms
    do_reset();
    for (int i = 0; i < 150; i++) begin
      byte_t b = pick_byte();
      if (i % 17 == 0) b = 8'h7F;
      if (i % 23 == 0) b = 8'hFF;
      if (ref_special(b)) begin dec_send(8'h18); dec_send(b ^ 8'h40); end
      else if (b == 8'h7F) begin dec_send(8'h18); dec_send(8'h6C); end
      else if (b == 8'hFF) begin dec_send(8'h18); dec_send(8'h6D); end
      else dec_send(b);
    end
    dec_idle();
    chk(esc_err_o == 0, "R5", "no error on clean stream", esc_err_o, 0);
    // either parity of escaped control code
    dec_send(8'h18); dec_send(8'hC1); dec_idle();

    // R8 header opener, with leading duplicate pad and a broken variant
    do_reset();
    dec_send(8'h2A); dec_send(8'h18); dec_send(8'h41); dec_idle(); dec_idle();
    dec_send(8'h2A); dec_send(8'h2A); dec_send(8'h18); dec_send(8'h41); dec_idle();
    dec_send(8'h2A); dec_send(8'h41); dec_idle();
    dec_send(8'h18); dec_send(8'h41); dec_idle();

    // R6 malformed escape
    do_reset();
    dec_send(8'h18); dec_send(8'h20); dec_idle();
    chk(esc_err_o == 1, "R6", "error set", esc_err_o, 1);
    dec_send(8'h33); dec_idle();
    chk(esc_err_o == 1, "R6", "error sticky", esc_err_o, 1);

    // R9 abort run: four then break, then five
    do_reset();
    repeat (4) dec_send(8'h18);
    dec_send(8'h00); dec_idle();
    chk(abort_o == 0, "R9", "run of four", abort_o, 0);
    repeat (5) dec_send(8'h18);
    dec_idle();
    chk(abort_o == 1, "R9", "run of five", abort_o, 1);
    dec_send(8'h00); dec_idle();
    chk(abort_o == 1, "R9", "abort sticky", abort_o, 1);

    summary();
    $finish;
  end
endmodule